// File: doc/BRIEF.md
# Monitor Timeslot Byte Handshake

This block moves bytes across the monitor timeslot of a framed serial bus. It can send and receive, and it uses two active-low handshake bits for flow control. MX marks a valid byte from the sender. MR acknowledges or rejects that byte from the receiver. Once per frame a strobe presents the slot contents seen on the receive line and the echo of the block's own transmit line. On that strobe the block registers the values it will drive in the next frame. Frame timing and register addressing belong to the surrounding logic.

Each side follows a fixed sequence.

- **Sending.** The sender loads one byte at a time. It holds the byte with MX low until the partner acknowledges it. It then releases MX for at least one frame before the next byte. Leaving MX high for two frames ends the message.
- **Receiving.** The receiver accepts a byte once it has seen the same byte in two consecutive frames with MX low. It answers with a one-frame MR pulse.
- **Aborting.** Either side can abort. A collision on the sender's own line also aborts.

Four sticky flags report events to the host, and a single interrupt line combines them.

Top module: `mon_hs`

## Requirements
- R1: After reset, the outputs are in this state:
  - `tx_mx`, `tx_mr` and `irq` are 1 only where stated here: `tx_mx` = 1, `tx_mr` = 1, `irq` = 0.
  - `tx_byte` = 8'hFF.
  - `host_rdata` = 0.
  - All four flags are 0.
- R2: While `ctl_mxc` = 0, the following hold:
  - `tx_mx` is 1 and `tx_byte` is 8'hFF.
  - Host writes are dropped.
  - The block is still idle when `ctl_mxc` returns to 1.
- R3: A host write is taken when `ctl_mxc` = 1 and no byte is outstanding. The byte is then driven with `tx_mx` = 0 starting at the next frame strobe. It stays driven on later strobes until it is acknowledged or aborted.
- R4: A host write made while a byte is outstanding is ignored. The driven byte stays unchanged.
- R5: An acknowledge occurs when, with a byte driven in both frames, `rx_mr` is 0 in one frame and 1 in the next. On that strobe the block does the following:
  - It sets `flg_dack`.
  - It returns `tx_mx` to 1, so a following byte always comes after at least one frame with MX = 1.
  - It frees the sender for the next byte.
- R6: A collision occurs when the echoed byte differs from the driven byte in any of its 8 bits, or when `echo_mx` = 1 in a frame where MX was driven low. On a collision the block sets `flg_abort` and returns `tx_mx` to 1 at that strobe.
- R7: If `rx_mr` is 0 in two consecutive frames while a byte is driven, the block treats it as a receiver abort. It sets `flg_abort` and returns `tx_mx` to 1.
- R8: The receiver accepts a byte when it has seen that byte with `rx_mx` = 0 in two consecutive frames, and at least one earlier frame had `rx_mx` = 1. On acceptance the block does the following:
  - It loads `host_rdata`.
  - It sets `flg_rdr`.
  - It drives `tx_mr` = 0 for exactly the next frame.
- R9: Two frames with different bytes are not accepted. After an accepted byte, no further byte is accepted until `rx_mx` has been 1 for a frame.
- R10: After an accepted byte, two consecutive frames with `rx_mx` = 1 set `flg_eor`.
- R11: A sender abort is detected when a byte was shown with `rx_mx` = 0 but never accepted, and `rx_mx` then stays 1 for two frames. In that case the block sets `flg_abort` instead of `flg_eor`.
- R12: A pulse on `rx_abort_req` makes `tx_mr` = 0 for the two frames after the next strobe.
- R13: While `ctl_mrc` = 0, the following hold:
  - `tx_mr` is 1.
  - No byte is accepted.
  - `tx_mr` is still 1 when `ctl_mrc` returns to 1.
- R14: Interrupt and flag clearing work as follows:
  - `irq` = `flg_rdr` | (`ctl_ie` & (`flg_eor` | `flg_dack` | `flg_abort`)).
  - A `stat_clr` pulse clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_stb | input | 1 | One-cycle pulse per frame; slot inputs valid |
| rx_byte | input | 8 | Monitor byte on the receive line |
| rx_mx | input | 1 | MX bit on the receive line (0 = active) |
| rx_mr | input | 1 | MR bit on the receive line (0 = active) |
| echo_byte | input | 8 | Monitor byte read back from the transmit line |
| echo_mx | input | 1 | MX bit read back from the transmit line |
| tx_byte | output | 8 | Monitor byte driven next frame |
| tx_mx | output | 1 | MX bit driven next frame |
| tx_mr | output | 1 | MR bit driven next frame |
| host_wdata | input | 8 | Byte to send |
| host_wr | input | 1 | Write strobe for host_wdata |
| rx_abort_req | input | 1 | Host request to abort reception |
| ctl_ie | input | 1 | Interrupt enable for eor/dack/abort |
| ctl_mxc | input | 1 | MX control; 0 keeps MX inactive |
| ctl_mrc | input | 1 | MR control; 0 keeps MR inactive |
| stat_clr | input | 1 | Clears all flags |
| host_rdata | output | 8 | Last accepted byte |
| flg_rdr | output | 1 | Data received |
| flg_eor | output | 1 | End of reception |
| flg_dack | output | 1 | Data acknowledged |
| flg_abort | output | 1 | Abort or collision |
| irq | output | 1 | Interrupt |

## Verification
The hardest situations to reach are collisions and the split between an acknowledge and a receiver abort. Both need the bus seen at the ports to disagree with what the block itself drives. The bench builds each frame's echo from the block's current outputs. It then flips one chosen bit, sweeping all eight data bits and the MX bit. For the second case it shapes the MR pattern so that a single low frame and a double low frame are presented while a byte is held. The sender-abort case is reached by showing one unconfirmed byte and then idling MX.

// File: rtl/mon_hs.sv
module mon_hs #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_mx,
  input  logic          rx_mr,
  input  logic [BW-1:0] echo_byte,
  input  logic          echo_mx,
  output logic [BW-1:0] tx_byte,
  output logic          tx_mx,
  output logic          tx_mr,
  input  logic [BW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          rx_abort_req,
  input  logic          ctl_ie,
  input  logic          ctl_mxc,
  input  logic          ctl_mrc,
  input  logic          stat_clr,
  output logic [BW-1:0] host_rdata,
  output logic          flg_rdr,
  output logic          flg_eor,
  output logic          flg_dack,
  output logic          flg_abort,
  output logic          irq
);

  logic [BW-1:0] xbyte_q, prev_byte;
  logic busy, xmx_q, mrlow_prev;
  logic prev_mx, armed, in_msg, unacc, abort_pend;
  logic [1:0] mr_cnt;

  assign tx_mx   = ~ctl_mxc | xmx_q;
  assign tx_byte = tx_mx ? '1 : xbyte_q;
  assign tx_mr   = ~(ctl_mrc && mr_cnt != 2'd0);
  assign irq     = flg_rdr | (ctl_ie & (flg_eor | flg_dack | flg_abort));

  wire drv     = ctl_mxc & ~xmx_q;
  wire collide = (echo_byte != xbyte_q) | echo_mx;
  wire tx_ack  = frame_stb & drv & ~collide & mrlow_prev & rx_mr;
  wire tx_abt  = frame_stb & drv & (collide | (mrlow_prev & ~rx_mr));

  wire rx_live = frame_stb & ctl_mrc & ~abort_pend;
  wire rx_acc  = rx_live & armed & ~rx_mx & ~prev_mx & (rx_byte == prev_byte);
  wire rx_end  = rx_live & rx_mx & prev_mx & (in_msg | unacc);
  wire rx_eor  = rx_end & ~unacc;
  wire rx_tabt = rx_end & unacc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; xmx_q <= 1'b1; xbyte_q <= '0; mrlow_prev <= 1'b0;
    end else if (!ctl_mxc) begin
      busy <= 1'b0; xmx_q <= 1'b1; mrlow_prev <= 1'b0;
    end else begin
      if (frame_stb) begin
        mrlow_prev <= drv & ~rx_mr;
        if (tx_ack || tx_abt) begin
          busy  <= 1'b0;
          xmx_q <= 1'b1;
        end else if (busy) begin
          xmx_q <= 1'b0;
        end
      end
      if (host_wr && !busy) begin
        busy    <= 1'b1;
        xbyte_q <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mx <= 1'b1; prev_byte <= '1; armed <= 1'b1; in_msg <= 1'b0;
      unacc <= 1'b0; mr_cnt <= 2'd0; abort_pend <= 1'b0;
    end else if (!ctl_mrc) begin
      prev_mx <= 1'b1; prev_byte <= '1; armed <= 1'b1; in_msg <= 1'b0;
      unacc <= 1'b0; mr_cnt <= 2'd0; abort_pend <= 1'b0;
    end else begin
      if (frame_stb) begin
        prev_mx   <= rx_mx;
        prev_byte <= rx_byte;
        if (abort_pend) begin
          mr_cnt <= 2'd2; abort_pend <= 1'b0;
          armed <= 1'b0; in_msg <= 1'b0; unacc <= 1'b0;
        end else begin
          if (mr_cnt != 2'd0) mr_cnt <= mr_cnt - 2'd1;
          if (rx_mx) armed <= 1'b1;
          if (rx_end) begin
            in_msg <= 1'b0; unacc <= 1'b0;
          end
          if (rx_acc) begin
            armed <= 1'b0; unacc <= 1'b0; in_msg <= 1'b1; mr_cnt <= 2'd1;
          end else if (!rx_mx && armed) begin
            unacc <= 1'b1;
          end
        end
      end
      if (rx_abort_req) abort_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (rx_acc) host_rdata <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_rdr <= 1'b0; flg_eor <= 1'b0; flg_dack <= 1'b0; flg_abort <= 1'b0;
    end else begin
      flg_rdr   <= (flg_rdr   & ~stat_clr) | rx_acc;
      flg_eor   <= (flg_eor   & ~stat_clr) | rx_eor;
      flg_dack  <= (flg_dack  & ~stat_clr) | tx_ack;
      flg_abort <= (flg_abort & ~stat_clr) | tx_abt | rx_tabt;
    end
  end

endmodule

module mon_hs_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          ctl_mxc,
  input logic          ctl_mrc,
  input logic          tx_mx,
  input logic          tx_mr,
  input logic [BW-1:0] tx_byte,
  input logic          echo_mx,
  input logic          stat_clr,
  input logic          flg_dack
);

  assert_mx_reenable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_mxc) |-> tx_mx);

  assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mx && $past(!tx_mx)) |-> tx_byte == $past(tx_byte));

  assert_dack_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_dack) |-> $past(frame_stb));

  assert_stop_on_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !tx_mx && echo_mx) |=> tx_mx);

  assert_mr_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_mr) |-> $past(frame_stb));

  assert_mr_reenable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_mrc) |-> tx_mr);

  assert_flag_clear_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_clr) && !$past(frame_stb)) |-> !flg_dack);

endmodule

bind mon_hs mon_hs_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ctl_mxc(ctl_mxc),
  .ctl_mrc(ctl_mrc), .tx_mx(tx_mx), .tx_mr(tx_mr), .tx_byte(tx_byte),
  .echo_mx(echo_mx), .stat_clr(stat_clr), .flg_dack(flg_dack)
);

// File: tb/mon_hs_tb.sv
`timescale 1ns/1ps
module mon_hs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 1'b0, rx_mx = 1'b1, rx_mr = 1'b1, echo_mx = 1'b1;
  logic [7:0] rx_byte = 8'hFF, echo_byte = 8'hFF, host_wdata = 8'h00;
  logic host_wr = 1'b0, rx_abort_req = 1'b0, stat_clr = 1'b0;
  logic ctl_ie = 1'b1, ctl_mxc = 1'b0, ctl_mrc = 1'b0;
  logic [7:0] tx_byte, host_rdata;
  logic tx_mx, tx_mr, flg_rdr, flg_eor, flg_dack, flg_abort, irq;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  mon_hs dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .rx_mx(rx_mx), .rx_mr(rx_mr), .echo_byte(echo_byte), .echo_mx(echo_mx),
    .tx_byte(tx_byte), .tx_mx(tx_mx), .tx_mr(tx_mr), .host_wdata(host_wdata),
    .host_wr(host_wr), .rx_abort_req(rx_abort_req), .ctl_ie(ctl_ie),
    .ctl_mxc(ctl_mxc), .ctl_mrc(ctl_mrc), .stat_clr(stat_clr),
    .host_rdata(host_rdata), .flg_rdr(flg_rdr), .flg_eor(flg_eor),
    .flg_dack(flg_dack), .flg_abort(flg_abort), .irq(irq)
  );

  task automatic ck(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frm(input logic [7:0] rb, input logic rmx, input logic rmr,
                     input logic [8:0] flip);
    @(negedge clk);
    rx_byte = rb; rx_mx = rmx; rx_mr = rmr;
    echo_byte = tx_byte ^ flip[7:0]; echo_mx = tx_mx ^ flip[8];
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic hwrite(input logic [7:0] d);
    @(negedge clk); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    ck("R1 tx_mx/tx_mr/irq", {tx_mx, tx_mr, irq}, 3'b110);
    ck("R1 tx_byte", tx_byte, 8'hFF);
    ck("R1 rdata", host_rdata, 8'h00);
    ck("R1 flags", {flg_rdr, flg_eor, flg_dack, flg_abort}, 4'b0000);

    // R2 / R13: both controls off
    hwrite(8'h55);
    frm(8'h33, 1'b1, 1'b1, 9'd0);
    frm(8'h33, 1'b0, 1'b1, 9'd0);
    frm(8'h33, 1'b0, 1'b1, 9'd0);
    ck("R2 mx held", {tx_mx, tx_byte}, {1'b1, 8'hFF});
    ck("R13 mr held", tx_mr, 1'b1);
    ck("R13 no accept", {flg_rdr, host_rdata}, {1'b0, 8'h00});
    @(negedge clk); ctl_mxc = 1'b1; ctl_mrc = 1'b1;
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R2 dropped write stays idle", tx_mx, 1'b1);
    ck("R13 mr after enable", tx_mr, 1'b1);

    // R3 start
    hwrite(8'hA5);
    ck("R3 not before strobe", tx_mx, 1'b1);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R3 drive", {tx_mx, tx_byte}, {1'b0, 8'hA5});
    // R4 write while outstanding
    hwrite(8'h3C);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R4 byte kept", {tx_mx, tx_byte}, {1'b0, 8'hA5});
    // R5 ack: MR low one frame then high
    frm(8'hFF, 1'b1, 1'b0, 9'd0);
    ck("R5 no ack yet", {tx_mx, flg_dack}, 2'b00);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R5 ack", {tx_mx, flg_dack}, 2'b11);
    ck("R14 irq dack", irq, 1'b1);
    clr();
    ck("R14 clear", {flg_dack, irq}, 2'b00);
    hwrite(8'h3C);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R5 next byte", {tx_mx, tx_byte}, {1'b0, 8'h3C});

    // R6 collision sweep over every data bit and MX
    for (int i = 0; i < 9; i++) begin
      frm(8'hFF, 1'b1, 1'b1, 9'(1) << i);
      ck($sformatf("R6 collide bit %0d", i), {tx_mx, flg_abort}, 2'b11);
      clr();
      hwrite(8'(8'h5A + i));
      frm(8'hFF, 1'b1, 1'b1, 9'd0);
      ck("R6 restart", {tx_mx, tx_byte}, {1'b0, 8'(8'h5A + i)});
    end

    // R7 receiver abort: MR low two frames
    frm(8'hFF, 1'b1, 1'b0, 9'd0);
    ck("R7 first low", {tx_mx, flg_abort, flg_dack}, 3'b000);
    frm(8'hFF, 1'b1, 1'b0, 9'd0);
    ck("R7 abort", {tx_mx, flg_abort, flg_dack}, 3'b110);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    clr();

    // R8 / R9 / R10 receive sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 5);
      frm(b, 1'b1, 1'b1, 9'd0);
      frm(b, 1'b0, 1'b1, 9'd0);
      ck("R8 single frame", {flg_rdr, tx_mr}, 2'b01);
      frm(b, 1'b0, 1'b1, 9'd0);
      ck("R8 accept", {flg_rdr, tx_mr, host_rdata}, {2'b10, b});
      clr();
      frm(b, 1'b0, 1'b1, 9'd0);
      ck("R9 no re-accept", {flg_rdr, tx_mr}, 2'b01);
      frm(8'hFF, 1'b1, 1'b1, 9'd0);
      ck("R10 one idle", flg_eor, 1'b0);
      frm(8'hFF, 1'b1, 1'b1, 9'd0);
      ck("R10 eor", {flg_eor, flg_abort}, 2'b10);
      clr();
    end

    // R9 differing bytes
    frm(8'h11, 1'b0, 1'b1, 9'd0);
    frm(8'h22, 1'b0, 1'b1, 9'd0);
    ck("R9 differ", flg_rdr, 1'b0);
    frm(8'h22, 1'b0, 1'b1, 9'd0);
    ck("R9 accept second", {flg_rdr, host_rdata}, {1'b1, 8'h22});
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R10 eor after differ", flg_eor, 1'b1);
    clr();

    // R11 sender abort, with R14 mask
    @(negedge clk); ctl_ie = 1'b0;
    frm(8'h44, 1'b0, 1'b1, 9'd0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R11 abort not eor", {flg_abort, flg_eor, flg_rdr}, 3'b100);
    ck("R14 masked irq", irq, 1'b0);
    @(negedge clk); ctl_ie = 1'b1;
    @(negedge clk);
    ck("R14 unmasked irq", irq, 1'b1);
    clr();
    @(negedge clk); ctl_ie = 1'b0;
    frm(8'h77, 1'b0, 1'b1, 9'd0);
    frm(8'h77, 1'b0, 1'b1, 9'd0);
    ck("R14 rdr irq unmasked", {flg_rdr, irq}, 2'b11);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    clr();
    @(negedge clk); ctl_ie = 1'b1;

    // R12 host abort request
    @(negedge clk); rx_abort_req = 1'b1;
    @(negedge clk); rx_abort_req = 1'b0;
    ck("R12 before strobe", tx_mr, 1'b1);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R12 low 1", tx_mr, 1'b0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R12 low 2", tx_mr, 1'b0);
    frm(8'hFF, 1'b1, 1'b1, 9'd0);
    ck("R12 released", tx_mr, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule